// File: doc/BRIEF.md
# Cascadable Command Parity Checker

This block checks an even-parity bit that a controller sends with each registered command/address word. It counts the ones across the shared data bits plus the parity bit, and drives an active-low error flag when the total is odd. It also drives a partial-parity result. When one word is split across two devices, the first device's partial parity is wired to the parity input of the second device, and only the second device reports the final error.

The configuration is given on two input pins, so one design covers three roles: a stand-alone checker, the leading half of a pair, and the trailing half of a pair. Chip-select gating matches the neighbouring register. A cycle in which both active-low selects are high captures nothing, and both outputs keep their values. The error flag is modelled as an ordinary active-low output. Per-module signals such as selects, clock enables and termination controls are not on `data_in`, so they never count toward parity.

Top module: `cmd_parity_chk`

## Requirements
- R1: With `cfg_pair`=0, `err_n` is 0 exactly when the captured `data_in` word together with the captured `par_in` holds an odd number of ones. Otherwise it is 1.
- R2: In stand-alone and leading roles, a word sampled at rising edge k shows its `err_n`/`pp_out` result from rising edge k+1.
- R3: In stand-alone and leading roles, `pp_out` is 1 when the captured word plus captured `par_in` holds an odd number of ones, and 0 when the count is even.
- R4: In the leading role (`cfg_pair`=1, `cfg_second`=0), `err_n` is held at 1.
- R5: In the trailing role (`cfg_pair`=1, `cfg_second`=1), a word sampled at edge k is checked against the `par_in` value sampled at edge k+2. From edge k+2, `err_n` is 0 exactly when that combination holds an odd count of ones.
- R6: A word sampled while `cs0_n` and `cs1_n` are both 1 is not captured. At the edge where its result would have appeared, `pp_out` and `err_n` stay unchanged.
- R7: Once `err_n` is 0, it stays 0 until a selected word with even parity reaches the output.
- R8: While `rst_n` is 0, `err_n` is 1 and `pp_out` is 0. Words sampled before reset never reach the outputs.
- R9: In a chained pair with the leader's `pp_out` driving the trailer's `par_in`, a single flipped bit on either device's data or on the controller parity drives the trailer's `err_n` to 0. A correct word keeps it at 1.
- R10: With `cfg_pair`=0, the value of `cfg_second` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pair | input | 1 | 1 selects the two-device chained arrangement |
| cfg_second | input | 1 | In a pair, 1 makes this the trailing device |
| cs0_n | input | 1 | Active-low chip select, first rank |
| cs1_n | input | 1 | Active-low chip select, second rank |
| data_in | input | DATA_W | Parity-covered command/address bits |
| par_in | input | 1 | Controller parity, or the leader's partial parity |
| err_n | output | 1 | Active-low parity error |
| pp_out | output | 1 | Partial parity result (1 = odd) |

## Verification
A word is sampled at rising edge k. In the stand-alone and leading roles, its partial parity and error are due at edge k+1. In the trailing role, the error is due at edge k+2, and the parity bit used is the one present just before edge k+2. The bench keeps a behavioural history of every sampled input, indexed by edge number. At each edge it computes the expected outputs from the entries one or two edges back, and it compares them on the following falling edge. A deselected or reset slot contributes no update, so holds and discards are checked at exactly the edge where a result would otherwise land.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_LEAD   = 2'd1,
        MODE_TAIL   = 2'd2
    } cpc_mode_e;

    typedef struct packed {
        logic pp;
        logic err_n;
    } cpc_out_t;

    function automatic cpc_mode_e cpc_decode(input logic pair, input logic second);
        if (!pair) begin
            return MODE_SINGLE;
        end else if (!second) begin
            return MODE_LEAD;
        end
        return MODE_TAIL;
    endfunction

endpackage

// File: rtl/cpc_xor_tree.sv
module cpc_xor_tree #(
    parameter int W     = 11,
    parameter int GROUP = 4
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    localparam int NG = (W + GROUP - 1) / GROUP;
    localparam int PW = NG * GROUP;

    logic [PW-1:0] padded;
    logic [NG-1:0] grp;

    always_comb begin
        padded         = '0;
        padded[W-1:0]  = vec;
    end

    // first level: fixed-size groups, second level: fold the group results
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp[g] = ^padded[g*GROUP +: GROUP];
    end

    assign odd = ^grp;

endmodule

// File: rtl/cpc_capture.sv
module cpc_capture #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic [W-1:0] data,
    input  logic         par,
    output logic [W-1:0] d1,
    output logic         p1,
    output logic         v1,
    output logic [W-1:0] d2,
    output logic         v2
);
    typedef struct packed {
        logic [W-1:0] d1;
        logic         p1;
        logic         v1;
        logic [W-1:0] d2;
        logic         v2;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.v1 = sel;
        if (sel) begin
            // deselected slots leave the capture register frozen
            cap_d.d1 = data;
            cap_d.p1 = par;
        end
        cap_d.d2 = cap_q.d1;
        cap_d.v2 = cap_q.v1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign d1 = cap_q.d1;
    assign p1 = cap_q.p1;
    assign v1 = cap_q.v1;
    assign d2 = cap_q.d2;
    assign v2 = cap_q.v2;

endmodule

// File: rtl/cpc_result.sv
module cpc_result
    import cpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cpc_mode_e mode,
    input  logic      odd1,
    input  logic      p1,
    input  logic      v1,
    input  logic      odd2,
    input  logic      par_live,
    input  logic      v2,
    output logic      pp,
    output logic      err_n
);
    cpc_out_t out_d, out_q;
    logic     near_sum;
    logic     far_sum;

    assign near_sum = odd1 ^ p1;
    assign far_sum  = odd2 ^ par_live;

    always_comb begin
        out_d = out_q;
        unique case (mode)
            MODE_SINGLE: begin
                if (v1) begin
                    out_d.pp    = near_sum;
                    out_d.err_n = ~near_sum;
                end
            end
            MODE_LEAD: begin
                out_d.err_n = 1'b1;
                if (v1) begin
                    out_d.pp = near_sum;
                end
            end
            MODE_TAIL: begin
                // chained parity arrives one slot after the local word
                if (v2) begin
                    out_d.pp    = far_sum;
                    out_d.err_n = ~far_sum;
                end
            end
            default: out_d = out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{pp: 1'b0, err_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign pp    = out_q.pp;
    assign err_n = out_q.err_n;

    // leading role never reports
    assert_lead_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEAD) |=> err_n);

endmodule

// File: rtl/cmd_parity_chk.sv
module cmd_parity_chk
    import cpc_pkg::*;
#(
    parameter int DATA_W    = 11,
    parameter int XOR_GROUP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pair,
    input  logic              cfg_second,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    output logic              err_n,
    output logic              pp_out
);
    localparam int NSTAGE = 2;

    cpc_mode_e         mode;
    logic              sel;
    logic [DATA_W-1:0] d1, d2;
    logic              p1, v1, v2;
    logic [NSTAGE-1:0] odd;
    logic [DATA_W-1:0] stage_word [NSTAGE];

    assign mode = cpc_decode(cfg_pair, cfg_second);
    assign sel  = ~(cs0_n & cs1_n);

    cpc_capture #(.W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .data  (data_in),
        .par   (par_in),
        .d1    (d1),
        .p1    (p1),
        .v1    (v1),
        .d2    (d2),
        .v2    (v2)
    );

    assign stage_word[0] = d1;
    assign stage_word[1] = d2;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_fold
        cpc_xor_tree #(.W(DATA_W), .GROUP(XOR_GROUP)) u_tree (
            .vec (stage_word[s]),
            .odd (odd[s])
        );
    end

    cpc_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .odd1     (odd[0]),
        .p1       (p1),
        .v1       (v1),
        .odd2     (odd[1]),
        .par_live (par_in),
        .v2       (v2),
        .pp       (pp_out),
        .err_n    (err_n)
    );

    assert_single_check_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel ##1 (mode == MODE_SINGLE) |=>
        (err_n == ~(^$past(data_in, 2) ^ $past(par_in, 2))));

    assert_partial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel ##1 (mode != MODE_TAIL) |=>
        (pp_out == (^$past(data_in, 2) ^ $past(par_in, 2))));

    assert_tail_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel ##2 (mode == MODE_TAIL) |=>
        (err_n == ~(^$past(data_in, 3) ^ $past(par_in, 1))));

    assert_gate_pp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel ##1 (mode != MODE_TAIL) |=> $stable(pp_out));

    assert_gate_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel ##1 (mode == MODE_SINGLE) |=> $stable(err_n));

    assert_gate_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel ##2 (mode == MODE_TAIL) |=> $stable(err_n));

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n ##1 !rst_n |-> (err_n && !pp_out));

endmodule

// File: tb/cmd_parity_chk_bench.sv
module cmd_parity_chk_bench;
    localparam int W    = 11;
    localparam int HMAX = 4096;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lead_pair = 1'b0;
    logic         lead_second = 1'b0;
    logic         cs0_n = 1'b1;
    logic         cs1_n = 1'b1;
    logic [W-1:0] da = '0;
    logic [W-1:0] db = '0;
    logic         par_ctrl = 1'b0;
    logic         lead_err_n, lead_pp;
    logic         tail_err_n, tail_pp;

    int nchk = 0;
    int nerr = 0;
    int phase = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmd_parity_chk #(.DATA_W(W)) u_cmd_parity_chk_lead (
        .clk(clk), .rst_n(rst_n), .cfg_pair(lead_pair), .cfg_second(lead_second),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .data_in(da), .par_in(par_ctrl),
        .err_n(lead_err_n), .pp_out(lead_pp)
    );

    cmd_parity_chk #(.DATA_W(W)) u_cmd_parity_chk (
        .clk(clk), .rst_n(rst_n), .cfg_pair(1'b1), .cfg_second(1'b1),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .data_in(db), .par_in(lead_pp),
        .err_n(tail_err_n), .pp_out(tail_pp)
    );

    // behavioural reference: history of sampled inputs, indexed by edge
    logic [W-1:0] h_da [HMAX];
    logic [W-1:0] h_db [HMAX];
    logic         h_par [HMAX];
    logic         h_sel [HMAX];
    int    cyc = 0;
    bit    started = 0;
    logic  m_lpp = 0, m_lerr = 1, m_tpp = 0, m_terr = 1;
    string t_lerr = "R8", t_lpp = "R8", t_terr = "R8";

    always @(posedge clk) begin
        logic before_lpp, s, single;
        int n;
        n = cyc;
        h_da[n]  = da;
        h_db[n]  = db;
        h_par[n] = par_ctrl;
        h_sel[n] = rst_n && !(cs0_n && cs1_n);
        single   = !lead_pair;
        before_lpp = m_lpp;
        if (!rst_n) begin
            m_lpp = 0; m_lerr = 1; m_tpp = 0; m_terr = 1;
            t_lerr = "R8"; t_lpp = "R8"; t_terr = "R8";
        end else begin
            if (!single) begin
                m_lerr = 1; t_lerr = "R4";
            end
            if (n >= 1 && h_sel[n-1]) begin
                s = ^h_da[n-1] ^ h_par[n-1];
                m_lpp = s; t_lpp = "R2 R3";
                if (single) begin
                    t_lerr = (m_lerr == 1'b0) ? "R7" : "R1 R2";
                    if (lead_second) t_lerr = {t_lerr, " R10"};
                    m_lerr = !s;
                end
            end else begin
                t_lpp = "R6";
                if (single) t_lerr = "R6";
            end
            if (n >= 2 && h_sel[n-2]) begin
                s = ^h_db[n-2] ^ before_lpp;
                m_tpp = s; m_terr = !s;
                t_terr = (phase == 2) ? "R9" : "R5";
            end else begin
                t_terr = "R6";
            end
        end
        cyc = cyc + 1;
        started = 1;
    end

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %b expected %b (edge %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(lead_pp, m_lpp, t_lpp, "lead pp_out");
            chk(lead_err_n, m_lerr, t_lerr, "lead err_n");
            chk(tail_err_n, m_terr, t_terr, "tail err_n");
        end
    end

    task automatic drive_select(input int unsigned r);
        bit desel;
        desel = (r % 5) == 0;
        cs0_n = desel ? 1'b1 : r[10];
        cs1_n = desel ? 1'b1 : (~r[10] & r[11]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // stand-alone role, random parity, cfg_second toggled (R1 R2 R3 R6 R7 R10)
        phase = 1;
        for (int i = 0; i < 300; i++) begin
            int unsigned r;
            r = $urandom;
            da = W'($urandom);
            db = W'($urandom);
            par_ctrl = r[3];
            lead_second = r[12];
            drive_select(r);
            @(negedge clk);
        end

        // reset with words in flight (R8)
        da = '1; par_ctrl = 1'b0; cs0_n = 1'b0; cs1_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cs0_n = 1'b1; cs1_n = 1'b1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // chained pair: correct parity with single-bit injections (R4 R5 R9)
        lead_pair = 1'b1;
        lead_second = 1'b0;
        phase = 2;
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom;
            da = W'($urandom);
            db = W'($urandom);
            par_ctrl = ^da ^ ^db;
            if ((r % 4) == 0) begin
                case ((r >> 4) % 3)
                    0: da[(r >> 8) % W] = ~da[(r >> 8) % W];
                    1: db[(r >> 8) % W] = ~db[(r >> 8) % W];
                    default: par_ctrl = ~par_ctrl;
                endcase
            end
            drive_select(r >> 12);
            @(negedge clk);
        end
        cs0_n = 1'b1; cs1_n = 1'b1;
        repeat (4) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule